// File: doc/BRIEF.md
# Audio Capture Sample Buffer

This block stores captured audio samples in a circular buffer of 16-bit words and hands them to software through a small 16-bit register interface. Samples arrive on a valid/ready stream. Each sample is reduced to one of four right-justified widths. A 16-bit sample takes one buffer word. A wider sample takes two words: the low 16 bits first, then the upper bits zero-extended. Software reads a data register to pop words in arrival order. It can read both pointers, start or stop recording, choose the width, and clear the buffer.

Three events can raise an interrupt: the stored amount reaching a threshold that software selects, an overrun, and a pulse from the external receiver. Each event sets a sticky status bit. Software clears a status bit by writing 1 to it. The interrupt line is the OR of every status bit that is enabled.

Stream rules: `smp_ready` is high only while recording is on. When it is low, the source keeps `smp_data` and waits. A sample counts as transferred in any cycle where `smp_valid` and `smp_ready` are both high. A transferred sample is still dropped, and flags an overrun, when the buffer does not have enough free words to hold it.

Top module: `capbuf_top`

## Requirements
- R1: After reset both pointers, the control register, the status register and the enable register read 0, and `irq` and `smp_ready` are low.
- R2: `smp_ready` equals the record bit, which is bit 0 of the control register at address 3. While that bit is clear, no word is written and the write pointer does not move.
- R3: The width field is bits 3:2 of the control register: 0 selects 16 bits, 1 selects 18, 2 selects 20 and 3 selects 24. Input bits above the selected width are discarded. Width 16 stores one word. The other widths store two words: the low 16 bits, then the remaining bits zero-extended.
- R4: A read of address 0 returns the oldest stored word and advances the read pointer by one. On an empty buffer it returns 0, and the pointer does not move.
- R5: The write pointer (address 1) and the read pointer (address 2) each give a word index that wraps modulo DEPTH.
- R6: A transferred sample that needs more words than are free is dropped whole. Stored data and the write pointer stay unchanged, and status bit 1 sets.
- R7: Enable register (address 5) bits 1:0 select the level threshold: 0 means off, 1 means DEPTH/8, 2 means DEPTH/4 and 3 means DEPTH/2. Status bit 0 sets when the stored word count moves from below the threshold to at or above it.
- R8: In the status register (address 4), a 1 written to a bit clears it. A pulse on `ext_evt` sets bit 2.
- R9: `irq` is high exactly when some status bit is set and enabled. Bit 0 is enabled by a nonzero level code, bit 1 by enable bit 2, and bit 2 by enable bit 3.
- R10: Writing 1 to control bit 1 zeroes both pointers and the status register in one cycle. The record bit and width field take the written values, and bit 1 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample accepted (recording on) |
| smp_data | input | 24 | Captured sample, right justified |
| ext_evt | input | 1 | Receiver event pulse |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 0) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16. At that size a few dozen pushes are enough to fill the buffer and trigger overrun in both the one-word and the two-word case. They also wrap both pointers more than twice. The bench sweeps all four sample widths and all four level codes, and at depth 16 every threshold (2, 4 and 8 words) can be stepped across one word at a time.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  localparam int REG_W = 16;
  localparam int SMP_W = 24;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_WPTR = 3'd1;
  localparam logic [2:0] ADDR_RPTR = 3'd2;
  localparam logic [2:0] ADDR_CTRL = 3'd3;
  localparam logic [2:0] ADDR_STAT = 3'd4;
  localparam logic [2:0] ADDR_IEN  = 3'd5;

  typedef enum logic [1:0] {FMT16 = 2'd0, FMT18 = 2'd1, FMT20 = 2'd2, FMT24 = 2'd3} fmt_e;
endpackage

// File: rtl/capbuf_pack.sv
module capbuf_pack
  import capbuf_pkg::*;
(
  input  fmt_e               fmt,
  input  logic [SMP_W-1:0]   din,
  output logic [REG_W-1:0]   lo_word,
  output logic [REG_W-1:0]   hi_word,
  output logic               two_words
);
  logic [SMP_W-1:0] keep;

  always_comb begin
    case (fmt)
      FMT16:   keep = {{(SMP_W-16){1'b0}}, {16{1'b1}}};
      FMT18:   keep = {{(SMP_W-18){1'b0}}, {18{1'b1}}};
      FMT20:   keep = {{(SMP_W-20){1'b0}}, {20{1'b1}}};
      default: keep = {SMP_W{1'b1}};
    endcase
  end

  logic [SMP_W-1:0] trimmed;
  assign trimmed   = din & keep;
  assign lo_word   = trimmed[REG_W-1:0];
  assign hi_word   = {{(2*REG_W-SMP_W){1'b0}}, trimmed[SMP_W-1:REG_W]};
  assign two_words = (fmt != FMT16);
endmodule

// File: rtl/capbuf_store.sv
module capbuf_store
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             two_words,
  input  logic [REG_W-1:0] lo_word,
  input  logic [REG_W-1:0] hi_word,
  input  logic             pop,
  output logic [REG_W-1:0] head_word,
  output logic [AW-1:0]    wptr,
  output logic [AW-1:0]    rptr,
  output logic [AW:0]      cnt,
  output logic [AW:0]      cnt_nxt,
  output logic             drop
);
  logic [REG_W-1:0] mem [DEPTH];
  logic [AW+1:0]    free_words;
  logic [AW+1:0]    need;
  logic             accept;
  logic             pop_ok;

  assign free_words = (AW+2)'(DEPTH) - {1'b0, cnt};
  assign need       = two_words ? (AW+2)'(2) : (AW+2)'(1);
  assign accept     = push && !clr && (free_words >= need);
  assign drop       = push && !clr && !accept;
  assign pop_ok     = pop && !clr && (cnt != '0);
  assign head_word  = (cnt != '0) ? mem[rptr] : '0;

  always_comb begin
    cnt_nxt = cnt;
    if (clr) cnt_nxt = '0;
    else begin
      if (accept) cnt_nxt = cnt_nxt + need[AW:0];
      if (pop_ok) cnt_nxt = cnt_nxt - (AW+1)'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wptr] <= lo_word;
      if (two_words) mem[wptr + AW'(1)] <= hi_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (clr) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (accept) wptr <= wptr + need[AW-1:0];
        if (pop_ok) rptr <= rptr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/capbuf_regs.sv
module capbuf_regs
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [3:0]       wdata,
  input  logic             ext_evt,
  input  logic             drop,
  input  logic [AW:0]      cnt,
  input  logic [AW:0]      cnt_nxt,
  output logic             rec,
  output fmt_e             fmt,
  output logic             clr,
  output logic [2:0]       status,
  output logic [3:0]       ien,
  output logic             irq
);
  logic [AW:0] thr;
  logic        lvl_evt;
  logic [2:0]  set_bits;
  logic [2:0]  w1c_bits;
  logic [2:0]  en_bits;

  always_comb begin
    case (ien[1:0])
      2'd1:    thr = (AW+1)'(DEPTH / 8);
      2'd2:    thr = (AW+1)'(DEPTH / 4);
      default: thr = (AW+1)'(DEPTH / 2);
    endcase
  end

  assign clr      = reg_wr && (reg_addr == ADDR_CTRL) && wdata[1];
  assign lvl_evt  = (ien[1:0] != 2'd0) && (cnt < thr) && (cnt_nxt >= thr);
  assign set_bits = {ext_evt, drop, lvl_evt};
  assign w1c_bits = (reg_wr && reg_addr == ADDR_STAT) ? wdata[2:0] : 3'b000;
  assign en_bits  = {ien[3], ien[2], ien[1:0] != 2'd0};
  assign irq      = |(status & en_bits);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec    <= 1'b0;
      fmt    <= FMT16;
      ien    <= '0;
      status <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) begin
        rec <= wdata[0];
        fmt <= fmt_e'(wdata[3:2]);
      end
      if (reg_wr && reg_addr == ADDR_IEN) ien <= wdata[3:0];
      if (clr) status <= '0;
      else     status <= (status & ~w1c_bits) | set_bits;
    end
  end
endmodule

// File: rtl/capbuf_top.sv
module capbuf_top
  import capbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_valid,
  output logic        smp_ready,
  input  logic [23:0] smp_data,
  input  logic        ext_evt,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  logic             rec, clr, drop, two_words, push, pop;
  fmt_e             fmt;
  logic [2:0]       status;
  logic [3:0]       ien;
  logic [REG_W-1:0] lo_word, hi_word, head_word;
  logic [AW-1:0]    wptr, rptr;
  logic [AW:0]      cnt, cnt_nxt;
  logic [11:0]      wdata_hi_unused;

  assign wdata_hi_unused = reg_wdata[15:4];
  assign smp_ready = rec;
  assign push      = smp_valid && rec;
  assign pop       = reg_rd && (reg_addr == ADDR_DATA);

  capbuf_pack u_pack (
    .fmt(fmt), .din(smp_data), .lo_word(lo_word), .hi_word(hi_word), .two_words(two_words)
  );

  capbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .two_words(two_words),
    .lo_word(lo_word), .hi_word(hi_word), .pop(pop), .head_word(head_word),
    .wptr(wptr), .rptr(rptr), .cnt(cnt), .cnt_nxt(cnt_nxt), .drop(drop)
  );

  capbuf_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .wdata(reg_wdata[3:0]),
    .ext_evt(ext_evt), .drop(drop), .cnt(cnt), .cnt_nxt(cnt_nxt), .rec(rec), .fmt(fmt),
    .clr(clr), .status(status), .ien(ien), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      ADDR_DATA: reg_rdata = head_word;
      ADDR_WPTR: reg_rdata = REG_W'(wptr);
      ADDR_RPTR: reg_rdata = REG_W'(rptr);
      ADDR_CTRL: reg_rdata = {12'b0, fmt, 1'b0, rec};
      ADDR_STAT: reg_rdata = {13'b0, status};
      ADDR_IEN:  reg_rdata = {12'b0, ien};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic [2:0]    reg_addr,
  input logic          reg_rd,
  input logic          irq,
  input logic          clr,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] rptr,
  input logic [AW:0]   cnt,
  input logic [2:0]    status
);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));

  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready && cnt == (AW+1)'(DEPTH) && !clr) |=> (wptr == $past(wptr)));

  p_idle_wptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_ready && !clr) |=> (wptr == $past(wptr)));

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0 && cnt == '0 && !clr) |=> (rptr == $past(rptr)));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'b000) |-> !irq);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wptr == '0 && rptr == '0 && cnt == '0 && status == 3'b000));
endmodule

bind capbuf_top capbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .reg_addr(reg_addr), .reg_rd(reg_rd), .irq(irq), .clr(clr),
  .wptr(wptr), .rptr(rptr), .cnt(cnt), .status(status)
);

// File: tb/capbuf_top_test.sv
`timescale 1ns/1ps
module capbuf_top_test;
  localparam int D = 16;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, ext_evt = 0, reg_wr = 0, reg_rd = 0;
  logic [23:0] smp_data = '0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        smp_ready, irq;
  logic [15:0] reg_rdata;

  int checks = 0, fails = 0;
  int mw = 0, mr = 0;
  logic [15:0] mq [D];
  logic [15:0] v;

  always #2 clk = ~clk;

  capbuf_top #(.DEPTH(D)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic push(input logic [23:0] s);
    @(negedge clk); smp_data = s; smp_valid = 1;
    @(posedge clk); #1 smp_valid = 0;
  endtask

  // bench model: returns 1 if stored, 0 if dropped
  function automatic bit model_push(input int f, input logic [23:0] s);
    int w; int need; logic [23:0] m;
    w = (f == 0) ? 16 : (f == 1) ? 18 : (f == 2) ? 20 : 24;
    m = s & ((24'h1 << w) - 1);
    if (w == 24) m = s;
    need = (f == 0) ? 1 : 2;
    if (D - (mw - mr) < need) return 0;
    mq[mw % D] = m[15:0]; mw++;
    if (need == 2) begin mq[mw % D] = {8'h0, m[23:16]}; mw++; end
    return 1;
  endfunction

  task automatic clear_start(input int f);
    wr(3'd3, 16'(2 | 1 | (f << 2)));
    mw = 0; mr = 0;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit stored;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); chk(v == 0, "R1 reg after reset", v, 0);
    end
    chk(irq == 0 && smp_ready == 0, "R1 irq/ready after reset", {irq, smp_ready}, 0);

    // R2 no capture while record clear
    push(24'h123456);
    rd(3'd1, v); chk(v == 0, "R2 wptr idle", v, 0);
    chk(smp_ready == 0, "R2 ready low", smp_ready, 0);

    // R3/R4/R5 sweep of formats
    for (int f = 0; f < 4; f++) begin
      clear_start(f);
      chk(smp_ready == 1, "R2 ready follows record", smp_ready, 1);
      for (int k = 0; k < 6; k++) begin
        logic [23:0] s;
        s = 24'(k * 24'h3A5C7 + f * 24'h111111) ^ 24'hF0F0F0;
        push(s); stored = model_push(f, s);
      end
      rd(3'd1, v); chk(v == 16'(mw % D), "R5 wptr word index", v, mw % D);
      while (mr < mw) begin
        rd(3'd0, v); chk(v == mq[mr % D], "R3 packed word", v, mq[mr % D]); mr++;
      end
      rd(3'd2, v); chk(v == 16'(mr % D), "R5 rptr word index", v, mr % D);
      rd(3'd0, v); chk(v == 0, "R4 empty read zero", v, 0);
      rd(3'd2, v); chk(v == 16'(mr % D), "R4 empty rptr still", v, mr % D);
    end

    // R5 wrap with interleaved push and pop
    clear_start(0);
    for (int k = 0; k < 40; k++) begin
      logic [23:0] s;
      s = 24'(k * 977 + 5);
      push(s); stored = model_push(0, s);
      rd(3'd0, v); chk(v == mq[mr % D], "R4 pop order", v, mq[mr % D]); mr++;
    end
    rd(3'd1, v); chk(v == 16'(mw % D), "R5 wptr wrapped", v, mw % D);
    rd(3'd2, v); chk(v == 16'(mr % D), "R5 rptr wrapped", v, mr % D);

    // R6 overrun with one-word samples
    clear_start(0);
    for (int k = 0; k < D; k++) begin push(24'(k + 100)); stored = model_push(0, 24'(k + 100)); end
    rd(3'd4, v); chk(v[1] == 0, "R6 no overrun when exactly full", v, 0);
    push(24'hBEEF); stored = model_push(0, 24'hBEEF);
    chk(stored == 0, "R6 model drop", stored, 0);
    rd(3'd4, v); chk(v[1] == 1, "R6 overrun flag", v[1], 1);
    rd(3'd1, v); chk(v == 0, "R6 wptr unchanged", v, 0);
    while (mr < mw) begin
      rd(3'd0, v); chk(v == mq[mr % D], "R6 unread data kept", v, mq[mr % D]); mr++;
    end
    rd(3'd0, v); chk(v == 0, "R6 nothing extra stored", v, 0);

    // R6 overrun with a two-word sample and one word free
    clear_start(0);
    push(24'h7); stored = model_push(0, 24'h7);
    wr(3'd3, 16'h0005);  // record, 18-bit
    for (int k = 0; k < 7; k++) begin push(24'(k * 3001)); stored = model_push(1, 24'(k * 3001)); end
    push(24'h3FFFF); stored = model_push(1, 24'h3FFFF);
    rd(3'd1, v); chk(v == 15, "R6 two-word drop keeps wptr", v, 15);
    rd(3'd4, v); chk(v[1] == 1, "R6 two-word overrun flag", v[1], 1);

    // R8 write-one-to-clear and external event
    wr(3'd4, 16'h0002);
    rd(3'd4, v); chk(v[1] == 0, "R8 w1c overrun", v, 0);
    @(negedge clk); ext_evt = 1; @(posedge clk); #1 ext_evt = 0;
    rd(3'd4, v); chk(v[2] == 1, "R8 ext event sets bit2", v, 4);

    // R9 interrupt gating
    wr(3'd5, 16'h0000);
    #1 chk(irq == 0, "R9 masked ext", irq, 0);
    wr(3'd5, 16'h0008);
    #1 chk(irq == 1, "R9 enabled ext", irq, 1);
    wr(3'd4, 16'h0004);
    #1 chk(irq == 0, "R9 cleared ext", irq, 0);
    wr(3'd5, 16'h0004);
    push(24'h1);
    #1 chk(irq == 1, "R9 enabled overrun", irq, 1);

    // R7 level thresholds for every code
    for (int code = 0; code < 4; code++) begin
      int thr;
      thr = (code == 0) ? 999 : (D >> (4 - code));
      wr(3'd5, 16'(code));
      clear_start(0);
      for (int n = 1; n <= 9; n++) begin
        push(24'(n));
        rd(3'd4, v);
        chk(v[0] == (n >= thr), "R7 level status", v[0], n >= thr);
        chk(irq == (n >= thr), "R9 level irq", irq, n >= thr);
      end
    end

    // R10 soft clear keeps configuration
    wr(3'd5, 16'h0004);
    push(24'h5); push(24'h6);
    wr(3'd3, 16'h000F);
    rd(3'd3, v); chk(v == 16'h000D, "R10 ctrl readback", v, 16'h000D);
    rd(3'd1, v); chk(v == 0, "R10 wptr cleared", v, 0);
    rd(3'd2, v); chk(v == 0, "R10 rptr cleared", v, 0);
    rd(3'd4, v); chk(v == 0, "R10 status cleared", v, 0);
    rd(3'd5, v); chk(v == 4, "R10 enable kept", v, 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule